// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Pin Claiming

This block controls a byte-wide general-purpose I/O port. Software reaches it through a single-cycle register interface that exposes three registers: an output latch, a read-only view of the pin levels, and a direction mask. Every pin can be steered by software as an input or an output. An on-chip peripheral, for example a serial transmitter or receiver, can also claim a pin. A claimed pin is forced to output (it then drives the peripheral's value) or to input, and the stored direction mask is left as it was.

Incoming pin levels pass through a two-flop synchronizer before any register read sees them. The pin-level register therefore always shows what is really on the wires, even for pins that are being driven. Software can compare that level against the value it drives to spot a shorted or overloaded output. When a peripheral releases a pin, the software direction bit controls that pin again.

Top module: `gpio_override_port`

## Requirements
- R1: A synchronous active-high reset clears the output latch, the direction mask and the synchronizer. After reset, every register reads 0, and pin_oe and pin_out are 0 when no peripheral claims a pin.
- R2: The direction mask sits at address 2 and can be written and read back at any time. For a pin that no peripheral claims, a bit of 1 drives pin_oe high (output) and a bit of 0 drives it low (input).
- R3: The output latch sits at address 0 and is loaded by a write. For every pin not claimed as a peripheral output, pin_out equals the latch bit, whatever the direction.
- R4: Reading address 1 returns each pin's level as it was two clock edges earlier, whatever the pin's direction. In the first edge after reset is released it still reads 0, and from the second edge it shows the pin.
- R5: A write to address 1 changes nothing. The latch and the direction mask keep their values, and the pin-level read keeps following the pins.
- R6: When per_en and per_force_out are both 1 for a pin, pin_oe is 1 and pin_out carries that pin's per_out bit.
- R7: When per_en is 1 and per_force_out is 0 for a pin, pin_oe is 0, whatever the direction mask holds.
- R8: A peripheral claim never alters the stored direction mask. Once per_en drops for a pin, the direction bit controls pin_oe again.
- R9: Reading address 0 returns the latch bit for each pin whose effective direction (claims included) is output, and the synchronized pin level for each pin whose effective direction is input.
- R10: Reading the unused address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 pin levels, 2 direction, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Asynchronous levels seen on the pads |
| pin_out | output | 8 | Value presented to the pad drivers |
| pin_oe | output | 8 | Per-pin output enable to the pads |
| per_en | input | 8 | Per-pin peripheral claim |
| per_force_out | input | 8 | For claimed pins: 1 forces output, 0 forces input |
| per_out | input | 8 | Peripheral drive value for pins it forces to output |

## Verification
The bench runs two kinds of claim, forced output and forced input, against a direction mask that says the opposite. It then reads the mask back. A design that let a claim write through to the stored bits would return a changed mask, and after the claim is released it would leave the pin pointing the wrong way. Latch reads are taken on ports that mix inputs and outputs, both with and without claims. A design that selected the read source by the stored mask instead of the effective direction would return wrong bits on exactly the claimed pins. The bench also writes to the read-only address and checks the input timing in the first two edges after reset. A missing or extra synchronizer stage shows up there as the pin value arriving one edge early or one edge late.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LATCH = 2'd0,
        REG_PINS  = 2'd1,
        REG_DIR   = 2'd2,
        REG_RSVD  = 2'd3
    } reg_sel_e;

    // Per-pin claim information from the peripheral side.
    typedef struct packed {
        logic en;
        logic force_out;
        logic value;
    } claim_t;

    // Per-pin resolved pad control.
    typedef struct packed {
        logic oe;
        logic drive;
    } pad_t;

    // Resolve one pin: a claim wins over software direction.
    function automatic pad_t resolve_pin(input claim_t c, input logic dir_bit,
                                         input logic latch_bit);
        pad_t p;
        if (c.en) begin
            p.oe    = c.force_out;
            p.drive = c.force_out ? c.value : latch_bit;
        end else begin
            p.oe    = dir_bit;
            p.drive = latch_bit;
        end
        return p;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = gpio_port_pkg::PORT_W,
    parameter int STAGES = gpio_port_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pin_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[k] <= '0;
            else     chain[k] <= chain[k-1];
        end
    end

    assign sync_out = chain[STAGES-1];

    if (STAGES == 2) begin : g_chk
        // R4: two edges of latency once reset has been clear for two edges
        assert_sync_latency_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2)) |-> (sync_out == $past(pin_in, 2)));
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);

    logic wr_latch;
    logic wr_dir;

    assign wr_latch = wr && (sel == REG_LATCH);
    assign wr_dir   = wr && (sel == REG_DIR);

    always_ff @(posedge clk) begin
        if (rst)           latch_q <= '0;
        else if (wr_latch) latch_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // R2: a direction write is visible on the next edge
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_DIR) |=> (dir_q == $past(wdata)));

    // R5: a write to the pin-level address touches no stored state
    assert_pins_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_PINS) |=> ($stable(latch_q) && $stable(dir_q)));

    // R8: the mask only moves on its own write
    assert_dir_only_by_write_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == REG_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] per_en,
    input  logic [W-1:0] per_force_out,
    input  logic [W-1:0] per_out,
    output logic [W-1:0] eff_oe,
    output logic [W-1:0] pin_out
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        claim_t c;
        pad_t   p;
        always_comb begin
            c.en        = per_en[i];
            c.force_out = per_force_out[i];
            c.value     = per_out[i];
            p           = resolve_pin(c, dir_q[i], latch_q[i]);
        end
        assign eff_oe[i]  = p.oe;
        assign pin_out[i] = p.drive;
    end

    // R7: a pin claimed as input never has its driver enabled
    assert_claim_in_R7: assert property (@(posedge clk) disable iff (rst)
        ((per_en & ~per_force_out & eff_oe) == '0));

    // R3: unclaimed-output pins present the latch
    assert_latch_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (((~(per_en & per_force_out)) & (pin_out ^ latch_q)) == '0));

endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    input  logic [W-1:0]  per_en,
    input  logic [W-1:0]  per_force_out,
    input  logic [W-1:0]  per_out
);

    reg_sel_e     sel;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pins_sync;
    logic [W-1:0] eff_oe;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.W(W)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .sync_out (pins_sync)
    );

    gpio_pin_ctl #(.W(W)) i_pins (
        .clk           (clk),
        .rst           (rst),
        .dir_q         (dir_q),
        .latch_q       (latch_q),
        .per_en        (per_en),
        .per_force_out (per_force_out),
        .per_out       (per_out),
        .eff_oe        (eff_oe),
        .pin_out       (pin_out)
    );

    assign pin_oe = eff_oe;

    // Read path: latch for driven pins, synchronized level for others.
    always_comb begin
        unique case (sel)
            REG_LATCH: bus_rdata = (latch_q & eff_oe) | (pins_sync & ~eff_oe);
            REG_PINS:  bus_rdata = pins_sync;
            REG_DIR:   bus_rdata = dir_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R8: unclaimed pins follow the stored mask
    assert_mask_controls_R8: assert property (@(posedge clk) disable iff (rst)
        (((~per_en) & (pin_oe ^ dir_q)) == '0));

    // R6: pins claimed as outputs are driven with the peripheral value
    assert_claim_out_R6: assert property (@(posedge clk) disable iff (rst)
        (((per_en & per_force_out) & ~(pin_oe & ~(pin_out ^ per_out))) == '0));

    // R10: the unused address reads as zero
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_override_port.sv
module test_gpio_override_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] per_en = 8'h00;
    logic [7:0] per_force_out = 8'h00;
    logic [7:0] per_out = 8'h00;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    gpio_override_port i_gpio_override_port (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pin_in        (pin_in),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .per_en        (per_en),
        .per_force_out (per_force_out),
        .per_out       (per_out)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] waddr;
        logic [7:0] wdata;
        logic [1:0] raddr;
        logic [7:0] pin;
        logic [7:0] en;
        logic [7:0] frc;
        logic [7:0] pout;
        logic [7:0] exp_rd;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 13;
    // address map: 0 latch, 1 pin levels, 2 direction, 3 unused
    localparam vec_t VECS [NV] = '{
        // R2: mask F0 drives upper four pins
        '{1'b1, 2'd2, 8'hF0, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0, 8'h00, 8'd2},
        // R9: latch A5 on a mixed port, pins 3C
        '{1'b1, 2'd0, 8'hA5, 2'd0, 8'h3C, 8'h00, 8'h00, 8'h00, 8'hAC, 8'hF0, 8'hA5, 8'd9},
        // R4: pin levels read back regardless of direction
        '{1'b0, 2'd0, 8'h00, 2'd1, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hF0, 8'hA5, 8'd4},
        // R5: write to pin-level address, mask intact
        '{1'b1, 2'd1, 8'hFF, 2'd2, 8'h5A, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0, 8'hA5, 8'd5},
        // R5: latch intact after that write
        '{1'b0, 2'd0, 8'h00, 2'd0, 8'h5A, 8'h00, 8'h00, 8'h00, 8'hAA, 8'hF0, 8'hA5, 8'd5},
        // R7: bit7 claimed as input, bit0 claimed as output (R6), mask unchanged
        '{1'b0, 2'd0, 8'h00, 2'd2, 8'h5A, 8'h81, 8'h01, 8'h00, 8'hF0, 8'h71, 8'hA4, 8'd7},
        // R9: latch read follows effective direction under claims
        '{1'b0, 2'd0, 8'h00, 2'd0, 8'h5A, 8'h81, 8'h01, 8'h00, 8'h2B, 8'h71, 8'hA4, 8'd9},
        // R8: release, mask controls again
        '{1'b0, 2'd0, 8'h00, 2'd2, 8'h5A, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0, 8'hA5, 8'd8},
        // R6: upper nibble claimed as output while mask is rewritten to 0F
        '{1'b1, 2'd2, 8'h0F, 2'd2, 8'h5A, 8'hF0, 8'hF0, 8'h30, 8'h0F, 8'hFF, 8'h35, 8'd6},
        // R9: every pin effectively output, latch returned
        '{1'b0, 2'd0, 8'h00, 2'd0, 8'h5A, 8'hF0, 8'hF0, 8'h30, 8'hA5, 8'hFF, 8'h35, 8'd9},
        // R3: latch cleared, unclaimed drive follows latch
        '{1'b1, 2'd0, 8'h00, 2'd0, 8'hC3, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h0F, 8'h00, 8'd3},
        // R10: unused address reads zero
        '{1'b0, 2'd0, 8'h00, 2'd3, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 8'd10},
        // R4: all inputs, pins FF
        '{1'b1, 2'd2, 8'h00, 2'd1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'd4}
    };

    task automatic chk(input int req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_at(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // R1: state after reset
        read_at(2'd0, rd); chk(1, "latch after reset", rd, 8'h00);
        read_at(2'd1, rd); chk(1, "pins after reset", rd, 8'h00);
        read_at(2'd2, rd); chk(1, "dir after reset", rd, 8'h00);
        chk(1, "oe after reset", pin_oe, 8'h00);
        chk(1, "out after reset", pin_out, 8'h00);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pin_in = VECS[v].pin;
            per_en = VECS[v].en;
            per_force_out = VECS[v].frc;
            per_out = VECS[v].pout;
            bus_addr = VECS[v].waddr;
            bus_wdata = VECS[v].wdata;
            bus_wr = VECS[v].wr;
            @(negedge clk);
            bus_wr = 1'b0;
            @(negedge clk);
            @(negedge clk);
            read_at(VECS[v].raddr, rd);
            chk(int'(VECS[v].req), "rdata", rd, VECS[v].exp_rd);
            chk(int'(VECS[v].req), "pin_oe", pin_oe, VECS[v].exp_oe);
            chk(int'(VECS[v].req), "pin_out", pin_out, VECS[v].exp_out);
        end

        // R1: reset in the middle of activity clears everything
        pin_in = 8'hFF;
        bus_write(2'd0, 8'h77);
        bus_write(2'd2, 8'hFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        read_at(2'd0, rd); chk(1, "latch in reset", rd, 8'h00);
        read_at(2'd2, rd); chk(1, "dir in reset", rd, 8'h00);
        read_at(2'd1, rd); chk(1, "pins in reset", rd, 8'h00);
        chk(1, "oe in reset", pin_oe, 8'h00);
        chk(1, "out in reset", pin_out, 8'h00);

        // R4: first edge after release still 0, second edge shows pins
        rst = 1'b0;
        @(negedge clk);
        read_at(2'd1, rd); chk(4, "pins one edge after release", rd, 8'h00);
        @(negedge clk);
        read_at(2'd1, rd); chk(4, "pins two edges after release", rd, 8'hFF);

        // R4: a pin change reaches the register after exactly two edges
        pin_in = 8'h0F;
        @(negedge clk);
        read_at(2'd1, rd); chk(4, "pin change after one edge", rd, 8'hFF);
        @(negedge clk);
        read_at(2'd1, rd); chk(4, "pin change after two edges", rd, 8'h0F);

        // R7: claim as input overrides an all-output mask; R8: mask readback
        bus_write(2'd2, 8'hFF);
        per_en = 8'h0C; per_force_out = 8'h00;
        #1;
        chk(7, "oe with input claim", pin_oe, 8'hF3);
        read_at(2'd2, rd); chk(8, "mask under input claim", rd, 8'hFF);
        per_en = 8'h00;
        #1;
        chk(8, "oe after release", pin_oe, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule